// File: doc/BRIEF.md
# Linear Image Sensor Readout Sequencer

This block drives a linear photodetector array whose clock drivers are built into the sensor. It needs only two control lines: an active-low shutter strobe and a pixel clock. On a start request the sequencer holds the shutter low for the programmed exposure. It then leaves a transfer gap and clocks out one frame of 2090 pixel pulses. A short, programmable time after each falling clock edge it fires a conversion strobe to an external converter. The converter's result is captured and streamed out with its pixel index.

The pixel clock rate, the exposure length and the sample delay are taken from the inputs when a request is accepted. They are clamped to safe limits and held fixed for that frame. A sensor that has just left reset, or has been idle too long, holds stale charge. Before the next real frame the block therefore runs flush trains: full clock trains with no shutter pulse, no conversions and no output. All timing is counted in system-clock cycles. The limits are parameters sized for a 100 MHz clock.

Top module: `lin_sensor_seq`

## Requirements
- R1: While rst_ni is low and after its release, rog_no and ccd_clk_o are 1 and conv_o, pix_valid_o and frame_done_o are 0.
- R2: An accepted request without flush drives rog_no low for max(exp_len_i, EXP_MIN) cycles. ccd_clk_o stays 1 for that whole time.
- R3: After rog_no returns to 1, ccd_clk_o stays 1 for exactly GAP_CYC plus one half period before its first fall.
- R4: A frame has 2090 falling edges of ccd_clk_o. Each high phase and each low phase lasts H = max(half_per_i, HALF_MIN) cycles.
- R5: conv_o is a one-cycle pulse given once per low phase of a real frame, while ccd_clk_o is 0. It falls at low-phase cycle min(settle_i, H-1), where the first low cycle counts as 0.
- R6: pix_valid_o is high for one cycle, in the first cycle after ccd_clk_o returns to 1. pix_data_o then equals adc_data_i from the last low cycle. pix_idx_o runs 0 to 2089 in order.
- R7: frame_done_o is high for one cycle, the cycle after the valid pixel with index 2089.
- R8: ccd_clk_o stays 1 after the last pixel. If start_i is held, rog_no falls exactly GAP_CYC+1 cycles after the last valid pixel.
- R9: start_i has no effect while a frame or flush is running. A held request yields exactly one frame of 2090 valid pixels before the engine returns to idle.
- R10: The first request after reset is preceded by FLUSH_FRAMES (2) dummy trains of 2090 falls each, before rog_no goes low. Dummy trains give no conv_o and no pix_valid_o.
- R11: A request that follows at least IDLE_LIMIT idle cycles since the last real frame gets the same flush. A request after a shorter idle gets none.
- R12: Changes to exp_len_i, half_per_i and settle_i after a request is accepted do not alter the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request, taken only when idle |
| exp_len_i | input | EXP_W | Exposure length in cycles |
| half_per_i | input | HALF_W | Pixel clock half period in cycles |
| settle_i | input | SET_W | Delay from falling clock edge to conversion strobe |
| adc_data_i | input | DW | Converter result |
| rog_no | output | 1 | Shutter strobe to sensor, active low |
| ccd_clk_o | output | 1 | Pixel clock to sensor |
| conv_o | output | 1 | Conversion start strobe |
| pix_data_o | output | DW | Captured pixel value |
| pix_idx_o | output | IDX_W | Pixel index 0..2089 |
| pix_valid_o | output | 1 | Pixel data and index valid |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The closing end gap of one frame and the acceptance of the next request can fall in the same cycle. The bench provokes this by holding start_i high through a whole frame and its end gap. The request arrives while the engine is busy and again in the very cycle the engine returns to idle. The result is judged from the ports. The first frame must still have exactly 2090 ordered pixels. The new shutter pulse must begin exactly GAP_CYC+1 cycles after the last valid pixel, and the input changes made during the first frame must not show up in its phase lengths or strobe positions.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXPO,
    ST_XGAP,
    ST_READ,
    ST_EGAP
  } lss_state_e;
endpackage

// File: rtl/lss_idle_mon.sv
module lss_idle_mon #(
  parameter int IDLE_LIMIT = 10_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic frame_end_i,
  input  logic flush_take_i,
  output logic flush_req_o
);
  localparam int CW = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(IDLE_LIMIT);

  logic [CW-1:0] cnt_q;
  logic          req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b1;   // sensor state unknown after reset
    end else begin
      if (frame_end_i)                 cnt_q <= '0;
      else if (idle_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      if (flush_take_i)                        req_q <= 1'b0;
      else if (idle_i && cnt_q == LIM - 1'b1)  req_q <= 1'b1;
    end
  end

  assign flush_req_o = req_q;

  a_r11_flush_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_take_i |=> !flush_req_o);
endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl
  import lss_pkg::*;
#(
  parameter int PULSES       = 2090,
  parameter int EXP_W        = 32,
  parameter int HALF_W       = 16,
  parameter int SET_W        = 8,
  parameter int EXP_MIN      = 500,
  parameter int HALF_MIN     = 25,
  parameter int GAP_CYC      = 500,
  parameter int FLUSH_FRAMES = 2,
  localparam int IDX_W = $clog2(PULSES),
  localparam int TW    = (EXP_W > HALF_W) ? EXP_W : HALF_W,
  localparam int FL_W  = $clog2(FLUSH_FRAMES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [EXP_W-1:0]  exp_len_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic [SET_W-1:0]  settle_i,
  input  logic              flush_req_i,
  output logic              rog_no,
  output logic              ccd_clk_o,
  output logic              conv_o,
  output logic              rise_o,
  output logic              dummy_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              idle_o,
  output logic              flush_take_o,
  output logic              frame_end_o
);
  lss_state_e        st_q;
  logic [TW-1:0]     tmr_q, half_q, conv_at_q;
  logic [EXP_W-1:0]  exp_q;
  logic [IDX_W-1:0]  pcnt_q;
  logic [FL_W-1:0]   fl_left_q;
  logic              clk_q, dummy_q, tick;

  // clamped request parameters
  logic [HALF_W-1:0] half_eff;
  logic [EXP_W-1:0]  exp_eff;
  logic [TW-1:0]     h_ext, s_ext, s_eff;

  always_comb begin
    half_eff = (half_per_i < HALF_W'(HALF_MIN)) ? HALF_W'(HALF_MIN) : half_per_i;
    exp_eff  = (exp_len_i < EXP_W'(EXP_MIN)) ? EXP_W'(EXP_MIN) : exp_len_i;
    h_ext    = TW'(half_eff);
    s_ext    = TW'(settle_i);
    s_eff    = (s_ext >= h_ext) ? h_ext - 1'b1 : s_ext;  // strobe ends before next rise
  end

  assign tick = (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      tmr_q     <= '0;
      half_q    <= TW'(HALF_MIN);
      conv_at_q <= '0;
      exp_q     <= EXP_W'(EXP_MIN);
      pcnt_q    <= '0;
      fl_left_q <= '0;
      clk_q     <= 1'b1;
      dummy_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          half_q    <= h_ext;
          conv_at_q <= h_ext - 1'b1 - s_eff;
          exp_q     <= exp_eff;
          if (flush_req_i) begin
            st_q      <= ST_READ;
            dummy_q   <= 1'b1;
            fl_left_q <= FL_W'(FLUSH_FRAMES - 1);
            tmr_q     <= h_ext - 1'b1;
          end else begin
            st_q  <= ST_EXPO;
            tmr_q <= TW'(exp_eff) - 1'b1;
          end
        end
        ST_EXPO: if (tick) begin
          st_q  <= ST_XGAP;
          tmr_q <= TW'(GAP_CYC - 1);
        end else tmr_q <= tmr_q - 1'b1;
        ST_XGAP: if (tick) begin
          st_q  <= ST_READ;
          tmr_q <= half_q - 1'b1;
        end else tmr_q <= tmr_q - 1'b1;
        ST_READ: if (tick) begin
          clk_q <= !clk_q;
          tmr_q <= half_q - 1'b1;
          if (!clk_q) begin
            if (pcnt_q == IDX_W'(PULSES - 1)) begin
              pcnt_q <= '0;
              st_q   <= ST_EGAP;
              tmr_q  <= TW'(GAP_CYC - 1);
            end else pcnt_q <= pcnt_q + 1'b1;
          end
        end else tmr_q <= tmr_q - 1'b1;
        ST_EGAP: if (tick) begin
          if (!dummy_q) st_q <= ST_IDLE;
          else if (fl_left_q == '0) begin
            dummy_q <= 1'b0;
            st_q    <= ST_EXPO;
            tmr_q   <= TW'(exp_q) - 1'b1;
          end else begin
            fl_left_q <= fl_left_q - 1'b1;
            st_q      <= ST_READ;
            tmr_q     <= half_q - 1'b1;
          end
        end else tmr_q <= tmr_q - 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rog_no       = (st_q != ST_EXPO);
  assign ccd_clk_o    = clk_q;
  assign rise_o       = (st_q == ST_READ) && !clk_q && tick;
  assign conv_o       = (st_q == ST_READ) && !clk_q && !dummy_q && (tmr_q == conv_at_q);
  assign dummy_o      = dummy_q;
  assign idx_o        = pcnt_q;
  assign idle_o       = (st_q == ST_IDLE);
  assign flush_take_o = (st_q == ST_IDLE) && start_i && flush_req_i;
  assign frame_end_o  = (st_q == ST_EGAP) && tick && !dummy_q;

  a_r4_idx_clear_outside_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_READ) |-> (pcnt_q == '0));
  a_r8_clk_high_in_gaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EGAP || st_q == ST_XGAP) |-> clk_q);
endmodule

// File: rtl/lss_sample.sv
module lss_sample #(
  parameter int DW     = 12,
  parameter int PULSES = 2090,
  localparam int IDX_W = $clog2(PULSES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             dummy_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    adc_i,
  output logic             valid_o,
  output logic [DW-1:0]    data_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      idx_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= rise_i && !dummy_i;
      if (rise_i && !dummy_i) begin
        data_o <= adc_i;
        idx_o  <= idx_i;
      end
      done_o <= valid_o && (idx_o == IDX_W'(PULSES - 1));
    end
  end

  a_r6_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (idx_o <= IDX_W'(PULSES - 1)));
endmodule

// File: rtl/lin_sensor_seq.sv
module lin_sensor_seq #(
  parameter int DW           = 12,
  parameter int EXP_W        = 32,
  parameter int HALF_W       = 16,
  parameter int SET_W        = 8,
  parameter int PULSES       = 2090,
  parameter int EXP_MIN      = 500,
  parameter int HALF_MIN     = 25,
  parameter int GAP_CYC      = 500,
  parameter int FLUSH_FRAMES = 2,
  parameter int IDLE_LIMIT   = 10_000_000,
  localparam int IDX_W = $clog2(PULSES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [EXP_W-1:0]  exp_len_i,
  input  logic [HALF_W-1:0] half_per_i,
  input  logic [SET_W-1:0]  settle_i,
  input  logic [DW-1:0]     adc_data_i,
  output logic              rog_no,
  output logic              ccd_clk_o,
  output logic              conv_o,
  output logic [DW-1:0]     pix_data_o,
  output logic [IDX_W-1:0]  pix_idx_o,
  output logic              pix_valid_o,
  output logic              frame_done_o
);
  logic             rise, dummy, idle, flush_take, frame_end, flush_req;
  logic [IDX_W-1:0] idx;

  lss_ctrl #(
    .PULSES(PULSES), .EXP_W(EXP_W), .HALF_W(HALF_W), .SET_W(SET_W),
    .EXP_MIN(EXP_MIN), .HALF_MIN(HALF_MIN), .GAP_CYC(GAP_CYC),
    .FLUSH_FRAMES(FLUSH_FRAMES)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .exp_len_i, .half_per_i, .settle_i,
    .flush_req_i(flush_req), .rog_no, .ccd_clk_o, .conv_o,
    .rise_o(rise), .dummy_o(dummy), .idx_o(idx), .idle_o(idle),
    .flush_take_o(flush_take), .frame_end_o(frame_end)
  );

  lss_idle_mon #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
    .clk_i, .rst_ni, .idle_i(idle), .frame_end_i(frame_end),
    .flush_take_i(flush_take), .flush_req_o(flush_req)
  );

  lss_sample #(.DW(DW), .PULSES(PULSES)) u_smp (
    .clk_i, .rst_ni, .rise_i(rise), .dummy_i(dummy), .idx_i(idx),
    .adc_i(adc_data_i), .valid_o(pix_valid_o), .data_o(pix_data_o),
    .idx_o(pix_idx_o), .done_o(frame_done_o)
  );

  a_r2_clk_high_expo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rog_no |-> ccd_clk_o);
  a_r6_valid_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> ccd_clk_o);
  a_r5_conv_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o |-> (!ccd_clk_o && rog_no));
endmodule

// File: tb/lin_sensor_seq_test.sv
module lin_sensor_seq_test;
  localparam int GAP = 20, EMIN = 50, HMIN = 2, IDLE = 3000, NPIX = 2090, WD = 190000;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [31:0] exp_len_i = 32'd50;
  logic [15:0] half_per_i = 16'd2;
  logic [7:0]  settle_i = 8'd0;
  logic [11:0] adc_data_i = '0;
  logic        rog_no, ccd_clk_o, conv_o, pix_valid_o, frame_done_o;
  logic [11:0] pix_data_o, pix_idx_o;

  always #5 clk_i = !clk_i;

  lin_sensor_seq #(
    .EXP_MIN(EMIN), .HALF_MIN(HMIN), .GAP_CYC(GAP), .IDLE_LIMIT(IDLE)
  ) uut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit wd = 0;
  // monitor state
  bit p_clk = 1, p_rog = 1, p_val = 0, rog_seen = 0, gap_on = 0;
  int p_idx = 0, low_cnt = 0, falls_tot = 0, falls_pre = 0, rog_cnt = 0, rog_len = 0;
  int gap_cnt = 0, first_gap = -1, low_bad = 0, conv_cnt = 0, conv_bad = 0, dummy_bad = 0;
  int val_cnt = 0, idx_bad = 0, data_bad = 0, val_bad = 0, exp_idx = 0, done_cnt = 0;
  int done_bad = 0, expo_bad = 0, lv_cyc = 0, rf_cyc = 0, e_half = 2, e_set = 0;

  function automatic logic [11:0] pat(int k);
    return 12'(k * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clr();
    rog_seen = 0; gap_on = 0; falls_tot = 0; falls_pre = 0; rog_cnt = 0; rog_len = 0;
    first_gap = -1; low_bad = 0; conv_cnt = 0; conv_bad = 0; dummy_bad = 0; val_cnt = 0;
    idx_bad = 0; data_bad = 0; val_bad = 0; exp_idx = 0; done_cnt = 0; done_bad = 0;
    expo_bad = 0;
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (cyc > WD && !wd) begin
      wd = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD);
    end
    if (rst_ni) begin
      if (!ccd_clk_o) begin
        if (p_clk) begin
          low_cnt = 0; falls_tot++;
          if (!rog_seen) falls_pre++;
          else adc_data_i = pat(falls_tot - falls_pre - 1);
        end else low_cnt++;
      end else if (!p_clk && low_cnt + 1 != e_half) low_bad++;
      if (conv_o) begin
        conv_cnt++;
        if (ccd_clk_o || low_cnt != e_set) conv_bad++;
        if (!rog_seen) dummy_bad++;
      end
      if (!rog_no) begin
        rog_cnt++;
        if (!ccd_clk_o) expo_bad++;
        if (p_rog) rf_cyc = cyc;
        rog_seen = 1;
      end else if (!p_rog) begin
        rog_len = rog_cnt; gap_on = 1; gap_cnt = 0;
      end
      if (gap_on) begin
        if (ccd_clk_o) gap_cnt++;
        else begin first_gap = gap_cnt; gap_on = 0; end
      end
      if (pix_valid_o) begin
        val_cnt++; lv_cyc = cyc;
        if (int'(pix_idx_o) != exp_idx) idx_bad++;
        if (pix_data_o != pat(int'(pix_idx_o))) data_bad++;
        if (!ccd_clk_o) val_bad++;
        if (!rog_seen) dummy_bad++;
        exp_idx++;
      end
      if (frame_done_o) begin
        done_cnt++;
        if (!(p_val && p_idx == NPIX - 1)) done_bad++;
      end
    end
    p_clk = ccd_clk_o; p_rog = rog_no; p_val = pix_valid_o; p_idx = int'(pix_idx_o);
  end

  task automatic wait_done();
    while (done_cnt == 0 && !wd) @(negedge clk_i);
  endtask

  task automatic frame_checks(input int ee, input int he, input int fl);
    chk(rog_len == ee, "R2 exposure length", rog_len, ee);
    chk(expo_bad == 0, "R2 clk high in exposure", expo_bad, 0);
    chk(first_gap == GAP + he, "R3 transfer gap", first_gap, GAP + he);
    chk(falls_tot - falls_pre == NPIX, "R4 pulses per frame", falls_tot - falls_pre, NPIX);
    chk(low_bad == 0, "R4 phase length", low_bad, 0);
    chk(conv_cnt == NPIX && conv_bad == 0, "R5 conv strobes", conv_cnt - conv_bad, NPIX);
    chk(val_cnt == NPIX && idx_bad == 0, "R6 index order", val_cnt - idx_bad, NPIX);
    chk(data_bad == 0 && val_bad == 0, "R6 pixel data", data_bad + val_bad, 0);
    chk(done_cnt == 1 && done_bad == 0, "R7 frame done", done_cnt - done_bad, 1);
    chk(falls_pre == fl * 2 * NPIX, (fl != 0) ? "R10 R11 flush trains" : "R11 no flush",
        falls_pre, fl * 2 * NPIX);
    chk(dummy_bad == 0, "R10 dummy silent", dummy_bad, 0);
  endtask

  task automatic run_frame(input int h, input int s, input int e, input int fl,
                           input int he, input int se, input int ee);
    @(negedge clk_i);
    clr(); e_half = he; e_set = se;
    half_per_i = 16'(h); settle_i = 8'(s); exp_len_i = 32'(e);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    repeat (GAP + 5) @(negedge clk_i);
    frame_checks(ee, he, fl);
  endtask

  // half, settle, exposure, flush expected, expected half, settle, exposure
  localparam int VEC[4][7] = '{
    '{2, 0, 10, 1, 2, 0, 50},
    '{3, 5, 60, 0, 3, 2, 60},
    '{1, 1, 80, 0, 2, 1, 80},
    '{5, 3, 50, 0, 5, 3, 50}
  };

  initial begin
    repeat (3) @(negedge clk_i);
    chk(rog_no && ccd_clk_o && !conv_o && !pix_valid_o && !frame_done_o,
        "R1 reset outputs", {rog_no, ccd_clk_o, conv_o, pix_valid_o, frame_done_o}, 5'b11000);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(rog_no && ccd_clk_o && !conv_o && !pix_valid_o && !frame_done_o,
        "R1 idle outputs", {rog_no, ccd_clk_o, conv_o, pix_valid_o, frame_done_o}, 5'b11000);

    for (int i = 0; i < 4; i++)
      run_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6]);

    // held request: busy ignore, input changes mid-frame, coincident restart
    @(negedge clk_i);
    clr(); e_half = 2; e_set = 1;
    half_per_i = 16'd2; settle_i = 8'd1; exp_len_i = 32'd50; start_i = 1'b1;
    while (!rog_seen && !wd) @(negedge clk_i);
    half_per_i = 16'd7; settle_i = 8'd9; exp_len_i = 32'd999;
    wait_done();
    half_per_i = 16'd2; settle_i = 8'd1; exp_len_i = 32'd50;
    chk(low_bad == 0 && conv_bad == 0 && rog_len == 50, "R12 latched params",
        low_bad + conv_bad, 0);
    chk(val_cnt == NPIX && idx_bad == 0, "R9 held start one frame", val_cnt, NPIX);
    clr();
    while (!rog_seen && !wd) @(negedge clk_i);
    start_i = 1'b0;
    chk(rf_cyc - lv_cyc == GAP + 1, "R8 end gap", rf_cyc - lv_cyc, GAP + 1);
    wait_done();
    repeat (GAP + 5) @(negedge clk_i);
    chk(val_cnt == NPIX && done_cnt == 1, "R9 second frame only", val_cnt, NPIX);

    // long idle forces flush again
    repeat (IDLE + 50) @(negedge clk_i);
    run_frame(2, 1, 50, 1, 2, 1, 50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule